// File: doc/BRIEF.md
# UART Sleep Mode Controller

This block holds the low-power state of a UART. It watches two enable bits from the control registers, the receiver's start-bit strobe, five asynchronous modem-side inputs, the host's transmit-write and receive-read strobes, the transmitter-idle flag, the receive-FIFO-empty flag and the interrupt-pending flag. From these it drives one output, `sleep_o`. A clock-gating stage outside the block would use this output to stop the internal clocks.

The block has three states. `ST_AWAKE_DISABLED` is the reset state, where sleep is not armed. `ST_AWAKE_ACTIVE` is armed and awake. `ST_ASLEEP` is armed and dozing, and `sleep_o` is high only in this state. The transitions are:

- **T_ARM**: DISABLED to ACTIVE, when both enables are set.
- **T_DOZE**: ACTIVE to ASLEEP. Activity must have been complete in the previous cycle and still be complete now. Complete means the transmitter is idle, the receive FIFO is empty, no interrupt is pending, no host strobe is present and no wake event is present.
- **T_WAKE**: ASLEEP to ACTIVE, on a start bit, a transmit write, a modem-input change or a pending interrupt.
- **T_DISARM**: ACTIVE or ASLEEP to DISABLED, whenever either enable is clear. This transition has priority over all others.

After a wake, the block goes back to sleep by itself through T_DOZE. No host action is needed.

Top module: `uart_doze_ctrl`

## Requirements
- R1: After reset the block is in the disabled state and `sleep_o` is 0.
- R2: `sleep_o` stays 0 unless both `feat_en_i` and `doze_en_i` are 1. Setting only one of them never raises it.
- R3: Armed from disabled with activity complete, `sleep_o` is still 0 after the first clock edge and becomes 1 after the second.
- R4: Sleep is never entered while `irq_pend_i` is 1. A pending interrupt while asleep drops `sleep_o` after the next edge. Once the interrupt clears, `sleep_o` returns after two edges.
- R5: A start-bit strobe `rx_start_i` while asleep drops `sleep_o` after the next edge.
- R6: A transmit write strobe `thr_wr_i` while asleep drops `sleep_o` after the next edge.
- R7: A level change on any bit of `modem_i` wakes the block. Each bit passes through two synchronizer flops and a history flop. `sleep_o` is still 1 after the second edge following the change and is 0 after the third.
- R8: After a wake, `sleep_o` stays 0 while `tx_idle_i` is 0, `rx_empty_i` is 0 or `irq_pend_i` is 1. It returns to 1 on the second edge after all three show completion.
- R9: A host read strobe `rhr_rd_i` or a write strobe restarts the quiet window. Sleep is not re-entered until the second edge after the last strobe.
- R10: Clearing `doze_en_i` sends the block to the disabled state after the next edge, and `sleep_o` stays 0 while it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en_i | input | 1 | Enhanced-feature enable bit for sleep |
| doze_en_i | input | 1 | Interrupt-enable sleep bit; clearing it disarms sleep |
| rx_start_i | input | 1 | Start-bit detected strobe from receiver |
| modem_i | input | NUM_MODEM | Asynchronous line inputs (RX, CTS, DSR, RI, DCD), any order |
| thr_wr_i | input | 1 | Host write to transmit holding register |
| rhr_rd_i | input | 1 | Host read of receive data |
| tx_idle_i | input | 1 | Transmitter has no character in progress |
| rx_empty_i | input | 1 | Receive FIFO holds no data |
| irq_pend_i | input | 1 | At least one interrupt pending |
| sleep_o | output | 1 | High only while in the asleep state |

## Verification
The hardest situation to reach from the ports is a wake caused by a modem-input change. The wake arrives three edges late because of the synchronizer pipeline, and a strobe, an interrupt or a disarm can land within that window. The directed part toggles each modem bit alone from a settled sleep and samples at every edge of the pipeline. The random part toggles modem bits rarely, so that they mix with host strobes, interrupts and occasional disarms. A bench-side cycle model tracks the expected state at every cycle.

// File: rtl/uart_doze_pkg.sv
package uart_doze_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE_DISABLED = 2'd0,
        ST_ASLEEP         = 2'd1,
        ST_AWAKE_ACTIVE   = 2'd2
    } doze_state_t;
endpackage

// File: rtl/doze_sync.sv
module doze_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign sync_o = stg[LAST];
endmodule

// File: rtl/doze_wake_detect.sv
module doze_wake_detect #(
    parameter int NUM_MODEM   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MODEM-1:0] modem_i,
    input  logic                 rx_start_i,
    input  logic                 thr_wr_i,
    output logic                 wake_o
);
    logic [NUM_MODEM-1:0] modem_sync;
    logic [NUM_MODEM-1:0] modem_hist;
    logic                 modem_chg;

    doze_sync #(.WIDTH(NUM_MODEM), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (modem_i),
        .sync_o  (modem_sync)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) modem_hist <= '0;
        else        modem_hist <= modem_sync;
    end

    assign modem_chg = |(modem_sync ^ modem_hist);
    assign wake_o    = modem_chg | rx_start_i | thr_wr_i;

    // A change seen now is absorbed into history by the next edge
    AST_CHG_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
        modem_chg |=> (modem_hist == $past(modem_sync))); // R7
endmodule

// File: rtl/uart_doze_ctrl.sv
module uart_doze_ctrl
    import uart_doze_pkg::*;
#(
    parameter int NUM_MODEM   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 feat_en_i,
    input  logic                 doze_en_i,
    input  logic                 rx_start_i,
    input  logic [NUM_MODEM-1:0] modem_i,
    input  logic                 thr_wr_i,
    input  logic                 rhr_rd_i,
    input  logic                 tx_idle_i,
    input  logic                 rx_empty_i,
    input  logic                 irq_pend_i,
    output logic                 sleep_o
);
    doze_state_t state_q, state_d;
    logic        wake_evt;
    logic        armed;
    logic        quiet_now;
    logic        quiet_q;

    doze_wake_detect #(.NUM_MODEM(NUM_MODEM), .SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .modem_i    (modem_i),
        .rx_start_i (rx_start_i),
        .thr_wr_i   (thr_wr_i),
        .wake_o     (wake_evt)
    );

    assign armed     = feat_en_i & doze_en_i;
    assign quiet_now = tx_idle_i & rx_empty_i & ~irq_pend_i
                     & ~thr_wr_i & ~rhr_rd_i & ~wake_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) quiet_q <= 1'b0;
        else        quiet_q <= quiet_now;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE_DISABLED: begin
                if (armed) state_d = ST_AWAKE_ACTIVE;                   // T_ARM
            end
            ST_AWAKE_ACTIVE: begin
                if (!armed)                      state_d = ST_AWAKE_DISABLED; // T_DISARM
                else if (quiet_q && quiet_now)   state_d = ST_ASLEEP;         // T_DOZE
            end
            ST_ASLEEP: begin
                if (!armed)                      state_d = ST_AWAKE_DISABLED; // T_DISARM
                else if (wake_evt || irq_pend_i) state_d = ST_AWAKE_ACTIVE;   // T_WAKE
            end
            default: state_d = ST_AWAKE_DISABLED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_AWAKE_DISABLED;
        else        state_q <= state_d;
    end

    always_comb begin
        sleep_o = (state_q == ST_ASLEEP);
    end

    AST_SLEEP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP) |-> $past(armed)); // R2
    AST_NO_SLEEP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> !$past(irq_pend_i)); // R4
    AST_WAKE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wake_evt) |=> !sleep_o); // R5
    AST_DOZE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> ($past(state_q) == ST_AWAKE_ACTIVE)); // R8
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        !doze_en_i |=> (state_q == ST_AWAKE_DISABLED)); // R10
endmodule

// File: tb/uart_doze_ctrl_tb.sv
module uart_doze_ctrl_tb;
    localparam int NM = 5;
    localparam int CLK_NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          feat_en = 1'b0, doze_en = 1'b0, rx_start = 1'b0;
    logic [NM-1:0] modem = '0;
    logic          thr_wr = 1'b0, rhr_rd = 1'b0, tx_idle = 1'b1, rx_empty = 1'b1, irq = 1'b0;
    logic          sleep;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    uart_doze_ctrl #(.NUM_MODEM(NM), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .feat_en_i(feat_en), .doze_en_i(doze_en),
        .rx_start_i(rx_start), .modem_i(modem), .thr_wr_i(thr_wr), .rhr_rd_i(rhr_rd),
        .tx_idle_i(tx_idle), .rx_empty_i(rx_empty), .irq_pend_i(irq), .sleep_o(sleep)
    );

    // Reference model: 0 disabled, 1 asleep, 2 active
    int            m_st;
    logic [NM-1:0] m_s1, m_s2, m_h;
    logic          m_quiet;

    function automatic int model_next(int st, bit arm, bit wake, bit irqp, bit qq, bit qn);
        if (!arm) return 0;
        if (st == 0) return 2;
        if (st == 2) return (qq && qn) ? 1 : 2;
        return (wake || irqp) ? 2 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_s1 <= '0; m_s2 <= '0; m_h <= '0; m_quiet <= 1'b0;
        end else begin
            bit wk, qn;
            wk = (|(m_s2 ^ m_h)) | rx_start | thr_wr;
            qn = tx_idle & rx_empty & ~irq & ~thr_wr & ~rhr_rd & ~wk;
            m_st    <= model_next(m_st, feat_en & doze_en, wk, irq, m_quiet, qn);
            m_quiet <= qn;
            m_s1 <= modem; m_s2 <= m_s1; m_h <= m_s2;
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk(string tag, logic exp);
        n_chk++;
        if (sleep !== exp) begin
            n_bad++;
            $display("FAIL %s: sleep_o actual=%b expected=%b at %0t", tag, sleep, exp, $time);
        end
    endtask

    task automatic pulse_thr();
        thr_wr = 1'b1; step(1); thr_wr = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        chk("R1 reset", 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after release", 1'b0);

        // R2: one enable alone never sleeps
        feat_en = 1'b1; step(4); chk("R2 feat only", 1'b0);
        feat_en = 1'b0; doze_en = 1'b1; step(4); chk("R2 doze only", 1'b0);

        // R3: arm with quiet system
        feat_en = 1'b1;
        step(1); chk("R3 first edge", 1'b0);
        step(1); chk("R3 second edge", 1'b1);

        // R5: start bit wakes, R8 re-sleep
        rx_start = 1'b1; step(1); rx_start = 1'b0;
        chk("R5 start wake", 1'b0);
        step(1); chk("R8 resleep edge1", 1'b0);
        step(1); chk("R8 resleep edge2", 1'b1);

        // R6: write wakes
        pulse_thr(); chk("R6 write wake", 1'b0);
        step(2); chk("R6 back asleep", 1'b1);

        // R9: read strobe restarts the quiet window
        pulse_thr();
        rhr_rd = 1'b1; step(1); rhr_rd = 1'b0;
        chk("R9 during read", 1'b0);
        step(1); chk("R9 edge1 after read", 1'b0);
        step(1); chk("R9 edge2 after read", 1'b1);

        // R7: each modem bit on its own
        for (int b = 0; b < NM; b++) begin
            modem[b] = ~modem[b];
            step(1); chk("R7 edge1", 1'b1);
            step(1); chk("R7 edge2", 1'b1);
            step(1); chk("R7 edge3 wake", 1'b0);
            step(2); chk("R7 resleep", 1'b1);
        end

        // R4: pending interrupt wakes and blocks entry
        irq = 1'b1; step(1); chk("R4 irq wake", 1'b0);
        step(5); chk("R4 held off", 1'b0);
        irq = 1'b0;
        step(1); chk("R4 edge1 after clear", 1'b0);
        step(1); chk("R4 edge2 after clear", 1'b1);

        // R8: busy transmitter / non-empty FIFO hold off re-sleep
        tx_idle = 1'b0; pulse_thr();
        step(5); chk("R8 tx busy", 1'b0);
        tx_idle = 1'b1; rx_empty = 1'b0;
        step(5); chk("R8 rx not empty", 1'b0);
        rx_empty = 1'b1;
        step(1); chk("R8 edge1 idle", 1'b0);
        step(1); chk("R8 edge2 idle", 1'b1);

        // R10: clear the sleep enable
        doze_en = 1'b0;
        step(1); chk("R10 disarm", 1'b0);
        pulse_thr(); step(6); chk("R10 stays off", 1'b0);
        doze_en = 1'b1;
        step(2); chk("R3 rearm", 1'b1);

        // Random phase against the bench model
        for (int i = 0; i < 4000; i++) begin
            int e;
            e = (m_st == 1) ? 1 : 0;
            chk("R2/R4/R5/R6/R7/R8/R9/R10 random", e[0]);
            feat_en  = ($urandom % 150) != 0;
            doze_en  = ($urandom % 150) != 0;
            rx_start = ($urandom % 23) == 0;
            thr_wr   = ($urandom % 29) == 0;
            rhr_rd   = ($urandom % 17) == 0;
            tx_idle  = ($urandom % 8) != 0;
            rx_empty = ($urandom % 6) != 0;
            irq      = ($urandom % 12) == 0;
            if (($urandom % 31) == 0) modem[$urandom % NM] ^= 1'b1;
            step(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule